// File: doc/BRIEF.md
# Floating-Point NaN Screen Before Register Writeback

This block sits between a floating-point arithmetic unit and the floating-point register file. When an instruction starts it takes the source operands, the result the arithmetic unit computed, the operand width code and the current control/status word. One clock later it presents the value to write, a write enable and the updated control/status word.

It clears the exception cause field of the status word at each instruction start. It then checks the source operands for NaNs. A signalling NaN among the sources is replaced by a fixed default quiet NaN. A quiet NaN among the sources is forwarded unchanged. In both cases the computed result is ignored. If no source is a NaN but the computed result is one, the block writes the default quiet NaN instead and records an invalid-operation exception. A width code that names no legal format raises an error and suppresses the write.

The NaN encoding follows the convention in which the most significant fraction bit set marks a signalling NaN. With that bit clear, the NaN is quiet.

Top module: `fpr_nan_screen`

## Requirements
- R1: On each start, the output status word equals the input status word with bits 17:12 (the cause field) cleared, apart from the invalid bits of R5. Bits 31:18 and 11:0 are carried over.
- R2: If a screened source operand is a signalling NaN, the write data is the default quiet NaN for the width. For single width this is 0x7FBFFFFF. For double width it is 0x7FF7FFFFFFFFFFFF. The computed result is not used, and no invalid bit is set.
- R3: If a screened source operand is a quiet NaN, its bit pattern is the write data unchanged, and no invalid bit is set. A NaN has an all-ones exponent and a nonzero fraction. It is quiet when the top fraction bit (bit 22 single, bit 51 double) is 0.
- R4: Source operands are examined from index 0 upward, and the first NaN found alone decides the write data.
- R5: If no source is a NaN and the computed result is a NaN, the write data is the default quiet NaN. In the same cycle, status bit 16 and status bit 6 are set.
- R6: When no NaN condition applies, the computed result is written. In every legal case, the write enable is a one-cycle pulse in the cycle after start.
- R7: Width code 0 selects single precision and code 1 selects double precision. Single precision uses bits 31:0 of every operand, and the write data then has bits 63:32 zero.
- R8: Width codes 2 and 3 raise the width error output for one cycle after start, with no write enable. The cause field is still cleared and no invalid bit is set.
- R9: While reset is high, the write enable, write data, width error and status output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction start strobe |
| width_sel | input | 2 | Operand width code (0 single, 1 double) |
| src_ops | input | 128 | Source operands, index 0 in bits 63:0 |
| calc_res | input | 64 | Result from the arithmetic unit |
| csr_in | input | 32 | Current control/status word |
| wr_data | output | 64 | Register write data |
| wr_en | output | 1 | Register write enable |
| csr_out | output | 32 | Updated control/status word |
| width_err | output | 1 | Illegal width code seen at start |

## Verification
The hardest cases to reach are those where two NaN rules compete. Examples are a quiet NaN in operand 0 with a signalling NaN in operand 1, or a NaN source together with a NaN result. In those cases the priority order alone decides the output. The bench sweeps every combination of normal, quiet-NaN and signalling-NaN values in both operands, paired with a normal and a NaN result, over all four width codes. It varies the payloads and the status word on each run. Single-width runs carry junk in the upper operand halves, which shows whether those bits leak into the write data.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;
  localparam int unsigned OPW = 64;
  localparam int unsigned CSRW = 32;
  localparam logic [1:0] FMT_SINGLE = 2'd0;
  localparam logic [1:0] FMT_DOUBLE = 2'd1;
  localparam logic [31:0] DEF_QNAN_S = 32'h7FBF_FFFF;
  localparam logic [63:0] DEF_QNAN_D = 64'h7FF7_FFFF_FFFF_FFFF;
  localparam int unsigned CAUSE_LO = 12;
  localparam int unsigned CAUSE_HI = 17;
  localparam int unsigned CAUSE_INV = 16;
  localparam int unsigned STICKY_INV = 6;

  typedef enum logic [1:0] {
    KIND_NUM    = 2'd0,
    KIND_QUIET  = 2'd1,
    KIND_SIGNAL = 2'd2
  } nan_kind_t;
endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify
  import fpnan_pkg::*;
(
  input  logic [OPW-1:0] value,
  input  logic           is_dbl,
  output nan_kind_t      kind
);
  logic exp_full;
  logic frac_nz;
  logic top_frac;

  always_comb begin
    if (is_dbl) begin
      exp_full = &value[62:52];
      frac_nz  = |value[51:0];
      top_frac = value[51];
    end else begin
      exp_full = &value[30:23];
      frac_nz  = |value[22:0];
      top_frac = value[22];
    end
    if (!(exp_full && frac_nz)) kind = KIND_NUM;
    else if (top_frac)          kind = KIND_SIGNAL;
    else                        kind = KIND_QUIET;
  end
endmodule

// File: rtl/fpnan_select.sv
module fpnan_select
  import fpnan_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][OPW-1:0] ops,
  input  nan_kind_t [NUM_SRC-1:0]     op_kind,
  input  logic [OPW-1:0]              res,
  input  nan_kind_t                   res_kind,
  input  logic                        is_dbl,
  output logic [OPW-1:0]              data,
  output logic                        raise_inv
);
  logic [OPW-1:0] dflt;
  logic [OPW-1:0] hi_mask;

  always_comb begin
    dflt    = is_dbl ? DEF_QNAN_D : {32'd0, DEF_QNAN_S};
    hi_mask = is_dbl ? '1 : {32'd0, 32'hFFFF_FFFF};
    if (res_kind != KIND_NUM) begin
      data      = dflt;
      raise_inv = 1'b1;
    end else begin
      data      = res & hi_mask;
      raise_inv = 1'b0;
    end
    // highest index first so that the lowest NaN index overrides
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (op_kind[i] == KIND_SIGNAL) begin
        data      = dflt;
        raise_inv = 1'b0;
      end else if (op_kind[i] == KIND_QUIET) begin
        data      = ops[i] & hi_mask;
        raise_inv = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpr_nan_screen.sv
module fpr_nan_screen
  import fpnan_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [1:0]             width_sel,
  input  logic [NUM_SRC*OPW-1:0] src_ops,
  input  logic [OPW-1:0]         calc_res,
  input  logic [CSRW-1:0]        csr_in,
  output logic [OPW-1:0]         wr_data,
  output logic                   wr_en,
  output logic [CSRW-1:0]        csr_out,
  output logic                   width_err
);
  localparam logic [CSRW-1:0] CAUSE_MASK =
    CSRW'(((1 << (CAUSE_HI - CAUSE_LO + 1)) - 1) << CAUSE_LO);
  localparam logic [CSRW-1:0] INV_BITS =
    CSRW'((1 << CAUSE_INV) | (1 << STICKY_INV));

  logic                        is_dbl;
  logic                        fmt_ok;
  logic [NUM_SRC-1:0][OPW-1:0] ops;
  nan_kind_t [NUM_SRC-1:0]     op_kind;
  nan_kind_t                   res_kind;
  logic [OPW-1:0]              sel_data;
  logic                        sel_inv;

  assign is_dbl = (width_sel == FMT_DOUBLE);
  assign fmt_ok = (width_sel == FMT_SINGLE) || (width_sel == FMT_DOUBLE);
  assign ops    = src_ops;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cls
    fpnan_classify u_cls (
      .value (ops[g]),
      .is_dbl(is_dbl),
      .kind  (op_kind[g])
    );
  end

  fpnan_classify u_res_cls (
    .value (calc_res),
    .is_dbl(is_dbl),
    .kind  (res_kind)
  );

  fpnan_select #(.NUM_SRC(NUM_SRC)) u_sel (
    .ops      (ops),
    .op_kind  (op_kind),
    .res      (calc_res),
    .res_kind (res_kind),
    .is_dbl   (is_dbl),
    .data     (sel_data),
    .raise_inv(sel_inv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_data   <= '0;
      wr_en     <= 1'b0;
      csr_out   <= '0;
      width_err <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      width_err <= 1'b0;
      if (start) begin
        if (fmt_ok) begin
          wr_en   <= 1'b1;
          wr_data <= sel_data;
          csr_out <= (csr_in & ~CAUSE_MASK) | (sel_inv ? INV_BITS : '0);
        end else begin
          width_err <= 1'b1;
          csr_out   <= csr_in & ~CAUSE_MASK;
        end
      end
    end
  end

  // R1: cause field cleared except invalid, other bits carried
  p_cause_clear_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> (csr_out[17] == 1'b0 && csr_out[15:12] == 4'd0 &&
               csr_out[31:18] == $past(csr_in[31:18]) &&
               csr_out[11:7] == $past(csr_in[11:7]) &&
               csr_out[5:0] == $past(csr_in[5:0])));

  // R6: write enable only the cycle after a start
  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(start));

  // R8: illegal width never writes
  p_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !fmt_ok) |=> (!wr_en && width_err && !csr_out[16]));

  // R5: invalid cause and sticky raised together with default quiet NaN
  p_inv_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && csr_out[16]) |->
      (csr_out[6] && (wr_data == DEF_QNAN_D || wr_data == {32'd0, DEF_QNAN_S})));

  // R7: single width leaves the upper write data half zero
  p_single_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (start && width_sel == FMT_SINGLE) |=> (wr_data[63:32] == 32'd0));
endmodule

// File: tb/sim_fpr_nan_screen.sv
module sim_fpr_nan_screen;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   width_sel = 2'd0;
  logic [127:0] src_ops = '0;
  logic [63:0]  calc_res = '0;
  logic [31:0]  csr_in = '0;
  logic [63:0]  wr_data;
  logic         wr_en;
  logic [31:0]  csr_out;
  logic         width_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fpr_nan_screen u0 (
    .clk(clk), .rst(rst), .start(start), .width_sel(width_sel),
    .src_ops(src_ops), .calc_res(calc_res), .csr_in(csr_in),
    .wr_data(wr_data), .wr_en(wr_en), .csr_out(csr_out), .width_err(width_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 number, 1 quiet NaN, 2 signalling NaN
  function automatic logic [63:0] make_val(input int kind, input bit dbl, input int p);
    logic [63:0] v;
    if (dbl) begin
      case (kind)
        0:       v = 64'h3FF0_0000_0000_0000 + 64'(p);
        1:       v = 64'h7FF0_0000_0000_0001 + 64'(p);
        default: v = 64'h7FF8_0000_0000_0000 | 64'(p);
      endcase
    end else begin
      case (kind)
        0:       v = {32'hDEAD_BEEF, 32'h3F80_0000 + 32'(p)};
        1:       v = {32'hCAFE_0000, 32'h7F80_0001 + 32'(p)};
        default: v = {32'h1234_5678, 32'h7FC0_0000 | 32'(p)};
      endcase
    end
    return v;
  endfunction

  initial begin
    int hang = 0;
    while (!done && hang < 100000) begin
      @(posedge clk);
      hang++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", hang);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] e_data, dq, mask;
    logic [31:0] e_csr;
    bit e_inv, dbl, legal;
    int n = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 wr_en", {63'd0, wr_en}, 64'd0);
    chk("R9 wr_data", wr_data, 64'd0);
    chk("R9 csr_out", {32'd0, csr_out}, 64'd0);
    chk("R9 width_err", {63'd0, width_err}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    for (int w = 0; w < 4; w++)
      for (int ka = 0; ka < 3; ka++)
        for (int kb = 0; kb < 3; kb++)
          for (int kr = 0; kr < 2; kr++) begin
            n++;
            dbl = (w == 1);
            legal = (w < 2);
            width_sel = 2'(w);
            src_ops[63:0]   = make_val(ka, dbl, n * 3);
            src_ops[127:64] = make_val(kb, dbl, n * 5 + 1);
            calc_res = make_val(kr, dbl, n * 7 + 2);
            csr_in = (n % 3 == 0) ? 32'hFFFF_FFFF : (n % 3 == 1) ? 32'h0 : 32'hA5A5_5A5A;
            start = 1'b1;
            mask = dbl ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
            dq = dbl ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h0000_0000_7FBF_FFFF;
            e_inv = 0;
            // R4: index 0 first
            if (ka == 2) e_data = dq;
            else if (ka == 1) e_data = src_ops[63:0] & mask;
            else if (kb == 2) e_data = dq;
            else if (kb == 1) e_data = src_ops[127:64] & mask;
            else if (kr == 1) begin e_data = dq; e_inv = 1; end
            else e_data = calc_res & mask;
            e_csr = (csr_in & ~32'h0003_F000) | ((e_inv && legal) ? 32'h0001_0040 : 32'h0);
            @(negedge clk);
            start = 1'b0;
            chk("R1 csr_out", {32'd0, csr_out}, {32'd0, e_csr});
            if (legal) begin
              chk("R6 wr_en", {63'd0, wr_en}, 64'd1);
              if (ka == 2 || (ka == 0 && kb == 2)) chk("R2 snan default", wr_data, e_data);
              else if (ka == 1 || kb == 1) chk("R3/R4 qnan pass", wr_data, e_data);
              else if (kr == 1) chk("R5 result nan", wr_data, e_data);
              else chk("R6/R7 result", wr_data, e_data);
              chk("R8 no err", {63'd0, width_err}, 64'd0);
            end else begin
              chk("R8 no write", {63'd0, wr_en}, 64'd0);
              chk("R8 width_err", {63'd0, width_err}, 64'd1);
            end
            @(negedge clk);
            chk("R6 pulse", {63'd0, wr_en}, 64'd0);
            chk("R8 err pulse", {63'd0, width_err}, 64'd0);
          end
    // R9: reset clears outputs after activity
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reset csr", {32'd0, csr_out}, 64'd0);
    chk("R9 reset data", wr_data, 64'd0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule